// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side half of a small serial memory. It watches an open-drain clock line and data line using a much faster system clock. It recognises start and stop conditions and collects bytes most significant bit first. It answers only to its own fixed device address. A matching address is acknowledged by pulling the data line low through an output-enable. A write transfer delivers a word address and then any number of data bytes to the memory-side block through strobes. A read transfer streams bytes taken from the memory side for as long as the master keeps acknowledging them.

The memory side owns the array and the address counter. It loads the counter on the address strobe and advances it on each write or read strobe. It presents the byte at the counter on the read-data input at all times. While the memory side raises its busy input, the engine is deaf to the bus.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data output-enable is low and no strobe (address load, write, read request, stop) is asserted.
- R2: A first byte after a start equal to 1010 000x (type code 1010 in bits 7..4, reserved bits 3..1 all zero) is acknowledged by pulling the data line low during the ninth clock.
- R3: A first byte whose type code differs from 1010, or whose reserved bits are not all zero, is not acknowledged, and every later byte and strobe is suppressed until the next start.
- R4: In a write transfer (bit 0 of the address byte = 0), the following byte is acknowledged, presented on the word-address output, and flagged by a one-cycle address-load strobe.
- R5: Each data byte after the word address is acknowledged, presented on the write-data output (first received bit in bit 7), and flagged by a one-cycle write strobe.
- R6: In a read transfer (bit 0 = 1), each byte taken from the read-data input is sent most significant bit first. A one-cycle read-request strobe is issued in the cycle each byte is taken.
- R7: In a read, if the master acknowledges then the next byte follows. If the master does not acknowledge, the engine releases the data line, takes no further byte and ignores clocks until a stop or start.
- R8: A stop condition (data rising while clock is high) gives a one-cycle stop strobe and returns the engine to idle, where bytes clocked without a new start are not acknowledged.
- R9: A start condition (data falling while clock is high) seen in the middle of a transfer restarts the address phase, so a repeated start can turn a write-address phase into a read.
- R10: While the busy input is high, the engine acknowledges nothing, including a matching address, and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe_o | output | 1 | High pulls the data line low |
| busy_i | input | 1 | Memory side busy; bus is ignored while high |
| rd_data_i | input | 8 | Byte at the memory-side address counter |
| addr_o | output | 8 | Last received word address |
| addr_load_o | output | 1 | One-cycle strobe: word address valid |
| wr_data_o | output | 8 | Last received data byte |
| wr_stb_o | output | 1 | One-cycle strobe: data byte valid |
| rd_req_o | output | 1 | One-cycle strobe: read byte taken, advance counter |
| stop_o | output | 1 | One-cycle strobe: stop condition seen |

## Verification
The engine is driven with a correct write address followed by two data bytes. This shows that acknowledges and strobes line up byte by byte. A random read uses a repeated start and three returned bytes, the last one not acknowledged. It separates streaming on acknowledge from the release on no acknowledge. Address bytes with a wrong type code, and with one reserved bit set, show that the engine ignores them until the next start. A matching address sent while busy shows that busy overrides the match. A byte clocked after a stop with no new start shows the return to idle.

// File: rtl/sms_pkg.sv
package sms_pkg;
    localparam int DW = 8;
    localparam int CW = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEVADDR,
        S_ACK_DEV,
        S_WORDADDR,
        S_ACK_WA,
        S_WDATA,
        S_ACK_WD,
        S_RDATA,
        S_RACK,
        S_HOLD
    } sms_state_t;

    typedef struct packed {
        sms_state_t    state;
        logic [CW-1:0] cnt;
        logic [DW-1:0] shreg;
        logic          oe;
        logic          rw;
        logic          ackd;
        logic [DW-1:0] waddr;
        logic [DW-1:0] wdata;
        logic          addr_load;
        logic          wr_stb;
        logic          rd_req;
        logic          stop;
    } sms_regs_t;
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] prev_d, prev_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;
        always_comb pipe_d = {pipe_q[STAGES-2:0], raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end
        assign lvl[g] = pipe_q[STAGES-1];
    end

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign sda_o      = lvl[1];
    assign scl_rise_o = lvl[0] & ~prev_q[0];
    assign scl_fall_o = ~lvl[0] & prev_q[0];
    assign start_o    = lvl[0] & prev_q[0] & prev_q[1] & ~lvl[1];
    assign stop_o     = lvl[0] & prev_q[0] & ~prev_q[1] & lvl[1];

    p_cond_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));
    p_edges_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise_o, scl_fall_o, start_o}));
endmodule

// File: rtl/sms_addr_match.sv
module sms_addr_match #(
    parameter int          DW        = 8,
    parameter logic [3:0]  TYPE_CODE = 4'b1010,
    parameter logic [2:0]  RSVD_BITS = 3'b000
) (
    input  logic [DW-1:0] byte_i,
    output logic          match_o,
    output logic          read_o
);
    localparam int TOP = DW - 1;

    always_comb begin
        match_o = (byte_i[TOP -: 4] == TYPE_CODE) && (byte_i[3:1] == RSVD_BITS);
        read_o  = byte_i[0];
    end
endmodule

// File: rtl/sms_ctrl.sv
module sms_ctrl
    import sms_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          sda_i,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          match_i,
    input  logic          read_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] shreg_o,
    output logic          sda_oe_o,
    output logic [DW-1:0] addr_o,
    output logic          addr_load_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_stb_o,
    output logic          rd_req_o,
    output logic          stop_o
);
    localparam logic [CW-1:0] BITS = CW'(DW);

    sms_regs_t d, q;

    always_comb begin
        d           = q;
        d.addr_load = 1'b0;
        d.wr_stb    = 1'b0;
        d.rd_req    = 1'b0;
        d.stop      = 1'b0;

        if (busy_i) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (start_i) begin
            d.state = S_DEVADDR;
            d.oe    = 1'b0;
            d.cnt   = '0;
        end else if (stop_i) begin
            d.state = S_IDLE;
            d.oe    = 1'b0;
            d.cnt   = '0;
            d.stop  = 1'b1;
        end else begin
            unique case (q.state)
                S_DEVADDR, S_WORDADDR, S_WDATA: begin
                    if (scl_rise_i && q.cnt < BITS) begin
                        d.shreg = {q.shreg[DW-2:0], sda_i};
                        d.cnt   = q.cnt + 1'b1;
                    end else if (scl_fall_i && q.cnt == BITS) begin
                        d.cnt = '0;
                        if (q.state == S_DEVADDR) begin
                            if (match_i) begin
                                d.oe    = 1'b1;
                                d.rw    = read_i;
                                d.state = S_ACK_DEV;
                            end else begin
                                d.state = S_HOLD;
                            end
                        end else if (q.state == S_WORDADDR) begin
                            d.oe        = 1'b1;
                            d.waddr     = q.shreg;
                            d.addr_load = 1'b1;
                            d.state     = S_ACK_WA;
                        end else begin
                            d.oe     = 1'b1;
                            d.wdata  = q.shreg;
                            d.wr_stb = 1'b1;
                            d.state  = S_ACK_WD;
                        end
                    end
                end
                S_ACK_DEV, S_ACK_WA, S_ACK_WD: begin
                    if (scl_fall_i) begin
                        d.cnt = '0;
                        if (q.state == S_ACK_DEV && q.rw) begin
                            d.shreg  = rd_data_i;
                            d.rd_req = 1'b1;
                            d.oe     = ~rd_data_i[DW-1];
                            d.state  = S_RDATA;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = (q.state == S_ACK_DEV) ? S_WORDADDR : S_WDATA;
                        end
                    end
                end
                S_RDATA: begin
                    if (scl_rise_i) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall_i) begin
                        if (q.cnt == BITS) begin
                            d.oe    = 1'b0;
                            d.cnt   = '0;
                            d.state = S_RACK;
                        end else begin
                            d.shreg = {q.shreg[DW-2:0], 1'b0};
                            d.oe    = ~q.shreg[DW-2];
                        end
                    end
                end
                S_RACK: begin
                    if (scl_rise_i) begin
                        d.ackd = ~sda_i;
                        d.cnt  = 4'd1;
                    end else if (scl_fall_i && q.cnt == 4'd1) begin
                        d.cnt = '0;
                        if (q.ackd) begin
                            d.shreg  = rd_data_i;
                            d.rd_req = 1'b1;
                            d.oe     = ~rd_data_i[DW-1];
                            d.state  = S_RDATA;
                        end else begin
                            d.oe    = 1'b0;
                            d.state = S_HOLD;
                        end
                    end
                end
                default: begin
                    d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign shreg_o     = q.shreg;
    assign sda_oe_o    = q.oe;
    assign addr_o      = q.waddr;
    assign addr_load_o = q.addr_load;
    assign wr_data_o   = q.wdata;
    assign wr_stb_o    = q.wr_stb;
    assign rd_req_o    = q.rd_req;
    assign stop_o      = q.stop;

    p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!q.oe && !q.addr_load && !q.wr_stb && !q.rd_req));
    p_stop_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.stop |-> (!q.oe && q.state == S_IDLE));
    p_oe_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> $past(scl_fall_i || start_i || stop_i || busy_i));
    p_hold_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_HOLD) |-> !q.oe);
    p_strobes_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.addr_load, q.wr_stb, q.rd_req, q.stop}));
    p_write_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_stb |-> q.oe);
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] TYPE_CODE   = 4'b1010,
    parameter logic [2:0] RSVD_BITS   = 3'b000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          busy_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [DW-1:0] addr_o,
    output logic          addr_load_o,
    output logic [DW-1:0] wr_data_o,
    output logic          wr_stb_o,
    output logic          rd_req_o,
    output logic          stop_o
);
    logic          sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic          match, rd_sel;
    logic [DW-1:0] shreg;

    sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    sms_addr_match #(.DW(DW), .TYPE_CODE(TYPE_CODE), .RSVD_BITS(RSVD_BITS)) u_match (
        .byte_i  (shreg),
        .match_o (match),
        .read_o  (rd_sel)
    );

    sms_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_i),
        .sda_i       (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_c),
        .stop_i      (stop_c),
        .match_i     (match),
        .read_i      (rd_sel),
        .rd_data_i   (rd_data_i),
        .shreg_o     (shreg),
        .sda_oe_o    (sda_oe_o),
        .addr_o      (addr_o),
        .addr_load_o (addr_load_o),
        .wr_data_o   (wr_data_o),
        .wr_stb_o    (wr_stb_o),
        .rd_req_o    (rd_req_o),
        .stop_o      (stop_o)
    );
endmodule

// File: tb/serial_mem_slave_tb_top.sv
module serial_mem_slave_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       busy = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] addr, wr_data;
    logic       sda_oe, addr_load, wr_stb, rd_req, stop_stb;
    logic       sda_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct { int kind; int val; } ev_t;
    ev_t exp_q[$];

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    logic [7:0] ptr = 8'h00;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;
    assign rd_data  = mem[ptr];

    serial_mem_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .busy_i(busy), .rd_data_i(rd_data), .addr_o(addr), .addr_load_o(addr_load),
        .wr_data_o(wr_data), .wr_stb_o(wr_stb), .rd_req_o(rd_req), .stop_o(stop_stb)
    );

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 8'((i * 37 + 11) & 255);
            ref_mem[i] = 8'((i * 37 + 11) & 255);
        end
    end

    // memory-side model
    always @(posedge clk) begin
        if (addr_load) ptr <= addr;
        if (wr_stb) begin mem[ptr] <= wr_data; ptr <= ptr + 8'd1; end
        if (rd_req) ptr <= ptr + 8'd1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int val);
        ev_t e;
        e.kind = kind; e.val = val;
        exp_q.push_back(e);
    endtask

    // monitor: kinds 1 addr_load, 2 write, 3 read request, 4 stop
    always @(negedge clk) begin
        if (rst_n && (addr_load || wr_stb || rd_req || stop_stb)) begin
            int k, v;
            ev_t e;
            k = addr_load ? 1 : wr_stb ? 2 : rd_req ? 3 : 4;
            v = addr_load ? int'(addr) : wr_stb ? int'(wr_data) : 0;
            if (exp_q.size() == 0) begin
                check(0, "R3/R10 unexpected strobe", k, 0);
            end else begin
                e = exp_q.pop_front();
                check(e.kind == k && e.val == v, "R4/R5/R6/R8 strobe", k * 256 + v, e.kind * 256 + e.val);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl = 0; wt(6); sda_m = 1; wt(6); scl = 1; wt(6); sda_m = 0; wt(6); scl = 0;
    endtask

    task automatic bus_stop(input bit expect_stb);
        if (expect_stb) push(4, 0);
        scl = 0; wt(6); sda_m = 0; wt(6); scl = 1; wt(6); sda_m = 1; wt(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            scl = 0; wt(6); sda_m = b[i]; wt(6); scl = 1; wt(12);
        end
        scl = 0; wt(6); sda_m = 1; wt(6); scl = 1; wt(6);
        acked = ~sda_line; wt(6);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            scl = 0; wt(6); sda_m = 1; wt(6); scl = 1; wt(6); b[i] = sda_line; wt(6);
        end
        scl = 0; wt(6); sda_m = give_ack ? 1'b0 : 1'b1; wt(6); scl = 1; wt(12);
    endtask

    initial begin
        bit ak;
        logic [7:0] rb;
        wt(3);
        check(sda_oe == 0, "R1 oe in reset", sda_oe, 0);
        rst_n = 1; wt(5);
        check(sda_oe == 0 && !addr_load && !wr_stb && !rd_req && !stop_stb,
              "R1 idle after reset", {sda_oe, addr_load, wr_stb, rd_req, stop_stb}, 0);

        // write: address, word address 0x10, two data bytes
        bus_start();
        send_byte(8'hA0, ak); check(ak, "R2 address ack", ak, 1);
        push(1, 8'h10);
        send_byte(8'h10, ak); check(ak, "R4 word address ack", ak, 1);
        push(2, 8'h5A); ref_mem[8'h10] = 8'h5A;
        send_byte(8'h5A, ak); check(ak, "R5 data ack 0", ak, 1);
        push(2, 8'hC3); ref_mem[8'h11] = 8'hC3;
        send_byte(8'hC3, ak); check(ak, "R5 data ack 1", ak, 1);
        bus_stop(1);
        check(sda_oe == 0, "R8 released after stop", sda_oe, 0);

        // random read with repeated start
        bus_start();
        send_byte(8'hA0, ak); check(ak, "R2 address ack (read setup)", ak, 1);
        push(1, 8'h10);
        send_byte(8'h10, ak); check(ak, "R4 word address ack", ak, 1);
        bus_start();
        push(3, 0);
        send_byte(8'hA1, ak); check(ak, "R9 ack after repeated start", ak, 1);
        push(3, 0);
        recv_byte(1, rb); check(rb == ref_mem[8'h10], "R6 read byte 0", rb, ref_mem[8'h10]);
        push(3, 0);
        recv_byte(1, rb); check(rb == ref_mem[8'h11], "R7 read byte 1 after ack", rb, ref_mem[8'h11]);
        recv_byte(0, rb); check(rb == ref_mem[8'h12], "R6 read byte 2", rb, ref_mem[8'h12]);
        recv_byte(1, rb); check(rb == 8'hFF, "R7 silent after nack", rb, 8'hFF);
        check(sda_oe == 0, "R7 oe low after nack", sda_oe, 0);
        bus_stop(1);

        // reserved bit set
        bus_start();
        send_byte(8'hA8, ak); check(!ak, "R3 reserved bit mismatch", ak, 0);
        send_byte(8'h20, ak); check(!ak, "R3 later byte ignored", ak, 0);
        send_byte(8'h77, ak); check(!ak, "R3 later byte ignored", ak, 0);
        bus_stop(1);

        // wrong type code
        bus_start();
        send_byte(8'hB0, ak); check(!ak, "R3 type code mismatch", ak, 0);
        bus_stop(1);

        // busy
        busy = 1;
        bus_start();
        send_byte(8'hA0, ak); check(!ak, "R10 no ack while busy", ak, 0);
        send_byte(8'h30, ak); check(!ak, "R10 byte ignored while busy", ak, 0);
        bus_stop(0);
        busy = 0; wt(4);

        // byte after stop without start
        send_byte(8'hA0, ak); check(!ak, "R8 no ack without start", ak, 0);
        bus_stop(1);

        // written data reached the memory side
        check(mem[8'h10] == 8'h5A, "R5 memory byte 0x10", mem[8'h10], 8'h5A);
        check(mem[8'h11] == 8'hC3, "R5 memory byte 0x11", mem[8'h11], 8'hC3);

        wt(10);
        check(exp_q.size() == 0, "R4/R6 missing strobes", exp_q.size(), 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule